// File: doc/BRIEF.md
# Burst-Averaging Sample Accumulator

This block sits between a 12-bit analog-to-digital converter and the logic that reads a potentiometer setting. A wiper that is bumped or worn gives short glitches. The block smooths them by averaging a burst of conversions. One start pulse is the only action software takes. After that pulse the block requests samples from the converter on its own. It adds up a configured number of them and divides the total by a power of two with a right shift.

When the last sample of the burst has been added, the block loads the mean into a right-aligned result register and pulses a done flag for one cycle. The result then stays unchanged until the next burst ends. For each accepted sample the block also gives a signed first-difference value, which is that sample minus the one before it. Software can use this value to judge how noisy the reading is.

Top module: `adc_avg_accum`

## Requirements
- R1: While reset is held, and afterwards until the first start, `sampleRequest`, `done`, `result` and `error` are all 0.
- R2: A `start` pulse while `sampleRequest` is low makes `sampleRequest` high from the next clock edge. It stays high until the edge at which the last sample of the burst is taken.
- R3: A sample is accepted only at a clock edge where `sampleValid` and `sampleRequest` are both high. A burst takes exactly the latched repeat count of such samples. Cycles with `sampleValid` low may come between them.
- R4: `result` is the sum of the burst's samples shifted right by the latched shift amount, zero-extended into the low bits of the 20-bit port. It changes only at the edge that takes the last sample.
- R5: `done` is high for exactly one cycle, starting at the edge that takes the last sample of a burst.
- R6: At each accepted sample, `error` becomes the new sample minus the previous sample of the same burst, as 13-bit two's complement. It is 0 for the first sample of a burst. It holds its value at edges where no sample is accepted.
- R7: A `start` pulse while `sampleRequest` is high is ignored. The burst continues and the running sum is not cleared.
- R8: `sampleValid` while `sampleRequest` is low is ignored: `result`, `error` and `done` do not change.
- R9: `cfgRepeat` and `cfgShift` are captured at start. Changing them later has no effect on the running burst. A repeat count of 0 is treated as 1.
- R10: The 20-bit accumulator does not overflow. 255 samples of 4095 with shift 0 give 1044225.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a burst |
| cfgRepeat | input | 8 | Number of samples per burst (0 counts as 1) |
| cfgShift | input | 5 | Right shift applied to the sum |
| sampleValid | input | 1 | Converter presents a sample this cycle |
| sampleData | input | 12 | Unsigned converter sample |
| sampleRequest | output | 1 | High while the burst wants samples |
| result | output | 20 | Right-aligned averaged result |
| error | output | 13 | Signed difference from the previous sample |
| done | output | 1 | One-cycle pulse when a burst completes |

## Verification
The assertions assume that `start` and `sampleValid` are driven to known levels from reset onward. They also assume that the converter does not raise `sampleValid` in a way that depends on `done` in the same cycle. The bench changes every input on the falling clock edge and holds `sampleValid` low outside bursts except in the one test that checks it is ignored. It always drives a repeat count no larger than 255, so the accumulator bound in R10 is never exceeded. Results are computed in the bench from the sample values it generates, and are compared after each rising edge.

// File: rtl/adc_avg_pkg.sv
package adc_avg_pkg;
  // Per-cycle strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic clearAcc;     // begin a new burst
    logic takeSample;   // add sampleData this cycle
    logic firstSample;  // this sample opens the burst
    logic lastSample;   // this sample closes the burst
  } ctrlStrobes_t;
endpackage

// File: rtl/adc_avg_ctrl.sv
module adc_avg_ctrl
  import adc_avg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             sampleValid,
  input  logic [CNT_W-1:0] cfgRepeat,
  output logic             busy,
  output logic             doneQ,
  output ctrlStrobes_t     strobes
);
  localparam int CW1 = CNT_W + 1;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t           stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] targetQ;
  logic [CNT_W-1:0] targetEff;
  logic [CW1-1:0]   cntInc;

  assign busy      = (stateQ == ST_RUN);
  assign targetEff = (cfgRepeat == '0) ? CNT_W'(1) : cfgRepeat;
  assign cntInc    = {1'b0, cntQ} + CW1'(1);

  always_comb begin
    strobes.clearAcc    = !busy && start;
    strobes.takeSample  = busy && sampleValid;
    strobes.firstSample = strobes.takeSample && (cntQ == '0);
    strobes.lastSample  = strobes.takeSample && (cntInc >= {1'b0, targetQ});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      cntQ    <= '0;
      targetQ <= CNT_W'(1);
      doneQ   <= 1'b0;
    end else begin
      doneQ <= strobes.lastSample;
      if (strobes.clearAcc) begin
        stateQ  <= ST_RUN;
        cntQ    <= '0;
        targetQ <= targetEff;
      end else if (strobes.takeSample) begin
        cntQ <= cntInc[CNT_W-1:0];
        if (strobes.lastSample) stateQ <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/adc_avg_dp.sv
module adc_avg_dp
  import adc_avg_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int CNT_W   = 8,
  parameter int SHIFT_W = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [DATA_W-1:0]       sampleData,
  input  logic [SHIFT_W-1:0]      cfgShift,
  output logic [DATA_W+CNT_W-1:0] result,
  output logic [DATA_W:0]         error
);
  localparam int ACC_W = DATA_W + CNT_W;
  localparam int ERR_W = DATA_W + 1;

  logic [ACC_W-1:0]   accQ;
  logic [ACC_W-1:0]   sumNext;
  logic [DATA_W-1:0]  prevQ;
  logic [SHIFT_W-1:0] shiftQ;
  logic [ERR_W-1:0]   diff;

  assign sumNext = accQ + ACC_W'(sampleData);
  assign diff    = {1'b0, sampleData} - {1'b0, prevQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ   <= '0;
      prevQ  <= '0;
      shiftQ <= '0;
      result <= '0;
      error  <= '0;
    end else begin
      if (strobes.clearAcc) begin
        accQ   <= '0;
        shiftQ <= cfgShift;
      end else if (strobes.takeSample) begin
        accQ  <= sumNext;
        prevQ <= sampleData;
        error <= strobes.firstSample ? '0 : diff;
        if (strobes.lastSample) result <= sumNext >> shiftQ;
      end
    end
  end
endmodule

// File: rtl/adc_avg_accum.sv
module adc_avg_accum
  import adc_avg_pkg::*;
#(
  parameter int DATA_W  = 12,
  parameter int CNT_W   = 8,
  parameter int SHIFT_W = 5,
  localparam int ACC_W  = DATA_W + CNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [CNT_W-1:0]   cfgRepeat,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  logic               sampleValid,
  input  logic [DATA_W-1:0]  sampleData,
  output logic               sampleRequest,
  output logic [ACC_W-1:0]   result,
  output logic [DATA_W:0]    error,
  output logic               done
);
  ctrlStrobes_t strobes;

  adc_avg_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
    .cfgRepeat(cfgRepeat), .busy(sampleRequest), .doneQ(done),
    .strobes(strobes)
  );

  adc_avg_dp #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleData(sampleData),
    .cfgShift(cfgShift), .result(result), .error(error)
  );
endmodule

// File: rtl/adc_avg_accum_chk.sv
module adc_avg_accum_chk #(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 8,
  localparam int ACC_W = DATA_W + CNT_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              sampleValid,
  input logic              sampleRequest,
  input logic [ACC_W-1:0]  result,
  input logic [DATA_W:0]   error,
  input logic              done
);
  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !sampleRequest) |=> sampleRequest);
  // R2
  request_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sampleRequest) |-> done);
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R5
  done_after_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(sampleRequest));
  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));
  // R6
  error_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleValid && sampleRequest) |-> $stable(error));
endmodule

bind adc_avg_accum adc_avg_accum_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
  .sampleRequest(sampleRequest), .result(result), .error(error), .done(done)
);

// File: tb/tb_adc_avg_accum.sv
`timescale 1ns/1ps
module tb_adc_avg_accum;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  cfgRepeat = 8'd32;
  logic [4:0]  cfgShift = 5'd5;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic        sampleRequest;
  logic [19:0] result;
  logic [12:0] error;
  logic        done;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  adc_avg_accum dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgRepeat(cfgRepeat),
    .cfgShift(cfgShift), .sampleValid(sampleValid), .sampleData(sampleData),
    .sampleRequest(sampleRequest), .result(result), .error(error), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] genSample(input int mode, input int i);
    case (mode)
      0: return 12'd1000;
      1: return 12'((i * 100) % 4096);
      2: return (i % 2 == 0) ? 12'd4095 : 12'd0;
      default: return 12'd4095;
    endcase
  endfunction

  // Runs one burst; options insert idle gaps, a start mid-burst, or a config change mid-burst
  task automatic runBurst(input int rep, input int sh, input int mode,
                          input bit gaps, input bit midStart, input bit midCfg,
                          input string tag);
    int eff;
    longint sum;
    logic [11:0] prev;
    logic [12:0] expErr;
    logic [19:0] expRes;
    eff = (rep == 0) ? 1 : rep;
    sum = 0;
    prev = '0;
    @(negedge clk);
    cfgRepeat = 8'(rep);
    cfgShift = 5'(sh);
    start = 1'b1;
    @(posedge clk); #1;
    chk(sampleRequest === 1'b1, {"R2 request after start ", tag}, sampleRequest, 1);
    for (int i = 0; i < eff; i++) begin
      if (gaps && (i % 2 == 1)) begin
        @(negedge clk);
        start = 1'b0;
        sampleValid = 1'b0;
        @(posedge clk); #1;
        chk(error === expErr, {"R6 error held in gap ", tag}, error, expErr);
        chk(done === 1'b0, {"R3 no done in gap ", tag}, done, 0);
      end
      @(negedge clk);
      start = (midStart && i == eff / 2) ? 1'b1 : 1'b0;
      if (midCfg && i == 1) begin
        cfgRepeat = 8'd2;
        cfgShift = 5'd0;
      end
      sampleValid = 1'b1;
      sampleData = genSample(mode, i);
      expErr = (i == 0) ? 13'd0 : 13'({1'b0, sampleData} - {1'b0, prev});
      prev = sampleData;
      sum += sampleData;
      @(posedge clk); #1;
      chk(error === expErr, {"R6 first difference ", tag}, error, expErr);
      chk(done === (i == eff - 1), {"R5 done timing ", tag}, done, (i == eff - 1));
      chk(sampleRequest === (i != eff - 1), {"R3 request level ", tag}, sampleRequest, (i != eff - 1));
    end
    expRes = 20'(sum >> sh);
    chk(result === expRes, {"R4 averaged result ", tag}, result, expRes);
    @(negedge clk);
    start = 1'b0;
    sampleValid = 1'b0;
    @(posedge clk); #1;
    chk(done === 1'b0, {"R5 done drops ", tag}, done, 0);
    chk(result === expRes, {"R4 result held ", tag}, result, expRes);
  endtask

  task automatic testReset();
    @(posedge clk); #1;
    chk(sampleRequest === 1'b0, "R1 request in reset", sampleRequest, 0);
    chk(done === 1'b0, "R1 done in reset", done, 0);
    chk(result === '0, "R1 result in reset", result, 0);
    chk(error === '0, "R1 error in reset", error, 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(sampleRequest === 1'b0, "R1 idle after reset", sampleRequest, 0);
    chk(result === '0, "R1 result idle", result, 0);
  endtask

  task automatic testIgnoredValid();
    logic [19:0] r0;
    logic [12:0] e0;
    r0 = result;
    e0 = error;
    @(negedge clk);
    sampleValid = 1'b1;
    sampleData = 12'd77;
    @(posedge clk); #1;
    chk(result === r0, "R8 result untouched", result, r0);
    chk(error === e0, "R8 error untouched", error, e0);
    chk(done === 1'b0, "R8 no done", done, 0);
    chk(sampleRequest === 1'b0, "R8 stays idle", sampleRequest, 0);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  initial begin
    testReset();
    runBurst(32, 5, 0, 1'b0, 1'b0, 1'b0, "R3 constant 32/5");
    runBurst(16, 4, 1, 1'b1, 1'b0, 1'b0, "R6 ramp with gaps");
    runBurst(4, 2, 2, 1'b0, 1'b0, 1'b0, "R6 alternating");
    runBurst(8, 3, 1, 1'b0, 1'b1, 1'b0, "R7 start mid burst");
    runBurst(8, 3, 2, 1'b0, 1'b0, 1'b1, "R9 config change");
    runBurst(0, 0, 1, 1'b0, 1'b0, 1'b0, "R9 repeat zero");
    testIgnoredValid();
    runBurst(255, 0, 3, 1'b0, 1'b0, 1'b0, "R10 full scale 255");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule